// File: doc/BRIEF.md
# ADC Scan Sequencer and Result Buffer

This block is the digital controller for a successive-approximation analog-to-digital converter. A sample trigger starts one conversion. The block waits for the next conversion-clock tick and then pulses a convert-start strobe. It holds a channel select steady until the converter hands back its result. Each result goes into a 16-slot result buffer, and software can read any slot through a read-address port.

A single 4-bit group-length value ties three events to one boundary. After `grp_len + 1` accepted results, the block raises a sticky interrupt, moves the buffer write pointer back to slot 0, and restarts the channel scan at the lowest selected channel. With scanning enabled, the channel comes from a 16-bit scan mask. The set bits are visited in ascending order, and the scan wraps when it runs out of set bits. With scanning disabled, or with an all-zero mask, a manual channel is used instead.

A done flag clears when a conversion starts and sets when its result is accepted. It then stays set through the next sample phase. The conversion clock is either the core clock divided by `div_sel + 1` or an external RC tick.

The result path is a valid/ready handshake. `res_ready` is high only while a conversion is waiting for its result. A result transfers in the cycle where both `res_valid` and `res_ready` are high. `res_valid` asserted while `res_ready` is low is ignored, and the converter must hold its result until ready. The block never stalls the converter once it is waiting.

Top module: `adc_scan_seq`

## Requirements
- R1: A `trig` pulse while idle arms the block. On the first conversion-clock tick after that, `conv_start` is high for exactly one cycle, and `ch_sel` stays constant from that cycle until the result is accepted.
- R2: With `rc_sel`=0, the conversion clock ticks once every `div_sel`+1 core-clock cycles, so `conv_start` follows an armed trigger within `div_sel`+2 cycles. With `rc_sel`=1, only `rc_tick` pulses produce ticks.
- R3: A `trig` pulse that arrives while a conversion is armed or in progress is ignored and causes no extra `conv_start`.
- R4: With `scan_en`=1 and a non-zero mask, successive conversions select the set bits of `scan_mask` in ascending channel order. After the highest set bit, the scan wraps to the lowest.
- R5: The first conversion of every group (after reset and after each group boundary) selects the lowest set bit of `scan_mask`, whatever channel came last.
- R6: With `scan_en`=0, or with `scan_mask` all zero, every conversion selects `man_ch`.
- R7: The k-th result of a group (k counted from 0) is written to slot k, whatever channel produced it. The pointer returns to slot 0 after `grp_len`+1 results. `rd_data` shows the slot addressed by `rd_addr` in the same cycle.
- R8: `irq` sets in the cycle after the (`grp_len`+1)-th result of a group is accepted. It stays set until `irq_clr` is pulsed, and a new setting event wins over a clear in the same cycle.
- R9: `done` is 0 after reset. It clears in the `conv_start` cycle and sets in the cycle after the result is accepted. It stays set through the following sample phase until the next `conv_start`.
- R10: `res_ready` is high only between `conv_start` and result acceptance. A `res_valid` pulse while `res_ready` is low changes no slot, no flag and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (instruction) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Channel scan enable |
| scan_mask | input | NCH (16) | One bit per analog input to include in the scan |
| man_ch | input | CW (4) | Channel used when scanning is off or the mask is zero |
| grp_len | input | GW (4) | Conversions per interrupt minus one |
| trig | input | 1 | Sample trigger pulse |
| rc_sel | input | 1 | 1: conversion clock from `rc_tick`; 0: divided core clock |
| div_sel | input | DIVW (6) | Core-clock divide factor minus one |
| rc_tick | input | 1 | Internal RC clock tick, one core cycle wide |
| ch_sel | output | CW (4) | Channel select to the converter |
| conv_start | output | 1 | One-cycle convert-start strobe |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Block ready to accept a result |
| res_data | input | DW (10) | Converter result |
| rd_addr | input | GW (4) | Result slot read address |
| rd_data | output | DW (10) | Content of slot `rd_addr` |
| irq | output | 1 | Sticky group-complete interrupt |
| irq_clr | input | 1 | Clears `irq` |
| done | output | 1 | Conversion-done flag |

## Verification
Trigger to armed state takes one edge. The strobe then rises on the next tick edge, so it is seen at the first falling edge after the trigger pulse drops when `div_sel`=0, or within `div_sel`+1 falling edges otherwise. A result accepted at an edge shows up in `done`, `irq` and the addressed slot at the falling edge that follows. The bench drives every input at falling edges and samples every output at a falling edge. A monitor pops the expected channel from a scoreboard queue at the exact falling edge where `conv_start` is seen. Ignored stimuli are checked by counting strobes and reading flags and slots over a quiet window afterwards.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
// Conversion-clock tick generator: divided core clock or external RC tick.
module adc_clk_div #(
  parameter int DIVW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rc_sel,
  input  logic [DIVW-1:0] div_sel,
  input  logic            rc_tick,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;
  logic            wrap;

  assign wrap = (cnt_q >= div_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (rc_sel || wrap)   cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick = rc_sel ? rc_tick : wrap;
endmodule

// File: rtl/adc_chan_pick.sv
// Chooses the channel for the next conversion from the scan mask.
module adc_chan_pick #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic           scan_en,
  input  logic           restart,
  input  logic [CW-1:0]  prev,
  input  logic [CW-1:0]  man_ch,
  output logic [CW-1:0]  ch
);
  logic [CW-1:0] first_ch, next_ch;
  logic          have_first, have_next;

  always_comb begin
    first_ch   = '0;
    next_ch    = '0;
    have_first = 1'b0;
    have_next  = 1'b0;
    // descending walk: the last hit is the lowest matching channel
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_ch   = CW'(i);
        have_first = 1'b1;
        if (i > int'(prev)) begin
          next_ch   = CW'(i);
          have_next = 1'b1;
        end
      end
    end
    if (!scan_en || !have_first)   ch = man_ch;
    else if (restart || !have_next) ch = first_ch;
    else                            ch = next_ch;
  end
endmodule

// File: rtl/adc_result_buf.sv
// Result slots: one write port, one combinational read port.
module adc_result_buf #(
  parameter int DW = 10,
  parameter int AW = 4,
  localparam int NSLOT = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [NSLOT];

  always_ff @(posedge clk) begin
    if (we) slot_q[waddr] <= wdata;
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int DW   = 10,
  parameter int DIVW = 6,
  parameter int GW   = 4,
  localparam int CW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  input  logic [NCH-1:0]  scan_mask,
  input  logic [CW-1:0]   man_ch,
  input  logic [GW-1:0]   grp_len,
  input  logic            trig,
  input  logic            rc_sel,
  input  logic [DIVW-1:0] div_sel,
  input  logic            rc_tick,
  output logic [CW-1:0]   ch_sel,
  output logic            conv_start,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [DW-1:0]   res_data,
  input  logic [GW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            irq,
  input  logic            irq_clr,
  output logic            done
);
  seq_state_e    state_q;
  logic [GW-1:0] grp_cnt_q;
  logic [CW-1:0] ch_q, last_ch_q, pick_ch;
  logic          start_q, done_q, irq_q;
  logic          tick, accept, grp_end;

  adc_clk_div #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .rc_sel(rc_sel), .div_sel(div_sel),
    .rc_tick(rc_tick), .tick(tick)
  );

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask(scan_mask), .scan_en(scan_en), .restart(grp_cnt_q == '0),
    .prev(last_ch_q), .man_ch(man_ch), .ch(pick_ch)
  );

  adc_result_buf #(.DW(DW), .AW(GW)) u_buf (
    .clk(clk), .we(accept), .waddr(grp_cnt_q), .wdata(res_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign accept  = (state_q == ST_CONV) && res_valid;
  assign grp_end = (grp_cnt_q == grp_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      grp_cnt_q <= '0;
      ch_q      <= '0;
      last_ch_q <= '0;
      start_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (trig) state_q <= ST_ARM;
        ST_ARM: if (tick) begin
          state_q <= ST_CONV;
          start_q <= 1'b1;
          ch_q    <= pick_ch;
          done_q  <= 1'b0;
        end
        ST_CONV: if (res_valid) begin
          state_q   <= ST_IDLE;
          done_q    <= 1'b1;
          last_ch_q <= ch_q;
          grp_cnt_q <= grp_end ? '0 : grp_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 irq_q <= 1'b0;
    else if (accept && grp_end) irq_q <= 1'b1;
    else if (irq_clr)           irq_q <= 1'b0;
  end

  assign ch_sel     = ch_q;
  assign conv_start = start_q;
  assign res_ready  = (state_q == ST_CONV);
  assign irq        = irq_q;
  assign done       = done_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           scan_en,
  input logic [NCH-1:0] scan_mask,
  input logic [CW-1:0]  ch_sel,
  input logic           conv_start,
  input logic           res_ready,
  input logic           done,
  input logic           irq,
  input logic           irq_clr
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R1
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready && !conv_start) |-> $stable(ch_sel)); // R1
  AST_SCAN_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && scan_en && (|scan_mask)) |-> scan_mask[ch_sel]); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R8
  AST_DONE_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !done); // R9
  AST_DONE_FALL_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> conv_start); // R9
  AST_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> res_ready); // R10
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) chk_i (.*);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0, trig = 1'b0, rc_sel = 1'b0, rc_tick = 1'b0, irq_clr = 1'b0;
  logic [15:0] scan_mask = '0;
  logic [3:0]  man_ch = '0, grp_len = '0, rd_addr = '0;
  logic [5:0]  div_sel = '0;
  logic [3:0]  ch_sel;
  logic        conv_start, res_ready, res_valid, irq, done;
  logic [9:0]  res_data, rd_data;
  logic        cv_valid = 1'b0, stray_valid = 1'b0;
  logic [9:0]  cv_data = '0;

  int nchk = 0, nfail = 0, nstart = 0, nconv = 0;
  logic [3:0] exp_ch_q[$];

  assign res_valid = cv_valid | stray_valid;
  assign res_data  = stray_valid ? 10'h3FF : cv_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_mask(scan_mask),
    .man_ch(man_ch), .grp_len(grp_len), .trig(trig), .rc_sel(rc_sel),
    .div_sel(div_sel), .rc_tick(rc_tick), .ch_sel(ch_sel),
    .conv_start(conv_start), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .irq_clr(irq_clr), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: returns {2'b10, channel, sequence id} LAT cycles after start
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        logic [3:0] c;
        c = ch_sel;
        repeat (LAT) @(negedge clk);
        cv_data  = {2'b10, c, 4'(nconv)};
        cv_valid = 1'b1;
        @(negedge clk);
        cv_valid = 1'b0;
        nconv++;
      end
    end
  end

  // monitor: compares the channel at each strobe with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        nstart++;
        if (exp_ch_q.size() == 0) check("R3 unexpected conv_start", 1, 0);
        else check("R4/R5/R6 channel at conv_start", int'(ch_sel), int'(exp_ch_q.pop_front()));
        check("R9 done low at start", int'(done), 0);
      end
    end
  end

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_done(input int s);
    while (nstart == s) @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  // driver: pushes the expected channel, triggers, waits for completion
  task automatic run_conv(input logic [3:0] ch, output logic [9:0] data);
    int s;
    s = nstart;
    data = {2'b10, ch, 4'(nconv)};
    exp_ch_q.push_back(ch);
    pulse_trig();
    wait_done(s);
  endtask

  task automatic read_slot(input logic [3:0] a, input logic [9:0] exp, input string tag);
    rd_addr = a;
    #1;
    check(tag, int'(rd_data), int'(exp));
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [9:0] d [4];
    logic [9:0] t;
    int s, dly;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 conv_start after reset", int'(conv_start), 0);
    check("R8 irq after reset", int'(irq), 0);
    check("R9 done after reset", int'(done), 0);
    check("R10 res_ready after reset", int'(res_ready), 0);

    // group of 4 over channels 2,5,7
    scan_en = 1'b1; scan_mask = 16'h00A4; grp_len = 4'd3;
    run_conv(4'd2, d[0]);
    run_conv(4'd5, d[1]);
    run_conv(4'd7, d[2]);
    check("R8 irq not before group end", int'(irq), 0);
    run_conv(4'd2, d[3]);
    check("R8 irq at group end", int'(irq), 1);
    for (int k = 0; k < 4; k++) read_slot(4'(k), d[k], "R7 slot by position");
    repeat (5) @(negedge clk);
    check("R8 irq sticky", int'(irq), 1);
    clr_irq();
    check("R8 irq cleared", int'(irq), 0);

    // second group restarts at lowest channel
    run_conv(4'd2, d[0]);
    read_slot(4'd0, d[0], "R7 pointer back to slot 0");
    run_conv(4'd5, d[1]);
    run_conv(4'd7, d[2]);
    run_conv(4'd2, d[3]);
    clr_irq();

    // done held through sample phase; divided tick latency
    div_sel = 6'd9;
    s = nstart;
    exp_ch_q.push_back(4'd2);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    check("R9 done held in sample phase", int'(done), 1);
    dly = 0;
    while (nstart == s && dly < 40) begin
      dly++;
      @(negedge clk);
    end
    check("R2 start within div_sel+2", int'(dly >= 1 && dly <= 11), 1);
    while (!done) @(negedge clk);
    run_conv(4'd5, t);
    run_conv(4'd7, t);
    run_conv(4'd2, t);
    clr_irq();

    // trigger during conversion ignored; group length 1
    div_sel = 6'd0; grp_len = 4'd0;
    s = nstart;
    exp_ch_q.push_back(4'd2);
    t = {2'b10, 4'd2, 4'(nconv)};
    pulse_trig();
    while (nstart == s) @(negedge clk);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R3 busy trigger ignored", nstart - s, 1);
    check("R8 irq every conversion", int'(irq), 1);
    read_slot(4'd0, t, "R7 group of one uses slot 0");
    clr_irq();
    run_conv(4'd2, t);
    clr_irq();

    // stray valid while idle
    @(negedge clk); stray_valid = 1'b1;
    @(negedge clk); stray_valid = 1'b0;
    @(negedge clk);
    check("R10 stray valid no irq", int'(irq), 0);
    read_slot(4'd0, t, "R10 stray valid no write");

    // manual channel
    man_ch = 4'd9; scan_en = 1'b0;
    run_conv(4'd9, t);
    clr_irq();
    scan_en = 1'b1; scan_mask = '0;
    run_conv(4'd9, t);
    clr_irq();

    // RC clock source
    rc_sel = 1'b1;
    s = nstart;
    exp_ch_q.push_back(4'd9);
    pulse_trig();
    repeat (30) @(negedge clk);
    check("R2 no start without rc_tick", nstart - s, 0);
    rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
    check("R2 start on rc_tick", int'(conv_start), 1);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 one strobe per conversion", nstart - s, 1);
    finish_run();
  end
endmodule